// File: doc/BRIEF.md
# Multi-Source Receive Path with Byte-Lane Rotator

This block carries received bus words to a 64-bit back-end output. It holds three internal queues: two DMA receive queues of 64 entries each, and one posted-write queue of 32 entries. Each entry is a 64-bit data word together with its 8 byte-enable bits. Upstream logic fills the queues through per-queue push ports. The back end pulls one word per cycle by raising a chip-select and naming the source on a 2-bit select input.

A 3-bit byte-select input rotates the chosen word by whole bytes before it is registered on the user clock. The enables rotate with their bytes, so back-end logic can realign or compact data without further shifting. A 2-bit byte-ID tag comes out with each word and reports the source it came from.

For the two DMA queues, the block reports an empty flag and an almost-empty flag. Each almost-empty flag compares the queue's occupancy against a threshold that is written through a small control port.

Top module: `rxPathTop`

## Requirements
- R1: After reset the output word, output enables, byte-ID and output valid are all zero, every queue is empty, and both almost-empty thresholds hold the value 4.
- R2: With chip-select high, source select 0 reads DMA queue 0, 1 reads DMA queue 1 and 2 reads the posted-write queue. The byte-ID output then carries that select value.
- R3: With byte-select 0, every data byte and every enable bit leaves in the lane it was pushed in.
- R4: With byte-select k, output lane i (bits 8i+7..8i) carries input lane (i+k) mod 8, and output enable bit i carries input enable bit (i+k) mod 8.
- R5: A pop goes only to the selected queue, and only when chip-select is high and that queue is not empty. Output valid is high in exactly the cycle after a pop. In every other cycle, valid is low and the output word, enables and byte-ID keep their previous values.
- R6: Source select 2'b11 is reserved. It pops no queue, drives valid low on the next cycle and leaves the output registers unchanged.
- R7: The DMA queues hold 64 words and the posted-write queue holds 32. A queue's full flag is high when it holds its capacity, and a push to a full queue is dropped even if the same cycle pops it. Words leave each queue in the order they were accepted.
- R8: The empty flag of DMA queue n (bit n of the empty output) is high exactly when that queue holds no words.
- R9: The almost-empty flag of DMA queue n is high when the queue's occupancy is less than or equal to its threshold. A cycle with the control write strobe high loads the control data into the threshold of queue 0 (select low) or queue 1 (select high). The new threshold takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushEn | input | 3 | Push strobe per queue (bit 0 DMA 0, bit 1 DMA 1, bit 2 posted-write) |
| pushData | input | 3x64 | Data word per queue |
| pushBe | input | 3x8 | Byte enables per queue |
| qFull | output | 3 | Full flag per queue |
| cs | input | 1 | Chip-select qualifying a transfer |
| srcSel | input | 2 | Source select, 2'b11 reserved |
| byteSel | input | 3 | Rotation amount in bytes |
| outData | output | 64 | Registered rotated data |
| outBe | output | 8 | Registered rotated byte enables |
| outByteId | output | 2 | Source tag of the current output word |
| outValid | output | 1 | High in the cycle after a pop |
| rxEmpty | output | 2 | Empty flags of the DMA queues |
| rxAlmostEmpty | output | 2 | Almost-empty flags of the DMA queues |
| cfgWe | input | 1 | Threshold write strobe |
| cfgSel | input | 1 | Threshold target, 0 or 1 |
| cfgThr | input | 7 | Threshold value |

## Verification
The hardest case to reach is a full queue that receives a push and a pop in the same cycle, since it needs a queue filled to capacity while the reader is also active. The stimulus reaches it by first overfilling the 32-entry posted-write queue with the reader idle. The random phase then biases pushes well above pops for long stretches, so queues reach capacity while pops are still being issued. Almost-empty boundaries come from thresholds rewritten during traffic, so occupancy crosses the threshold in both directions.

// File: rtl/rxPathPkg.sv
package rxPathPkg;
  localparam int LANES  = 8;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam int ROT_W  = $clog2(LANES);
  localparam int NSRC   = 3;
  localparam int WORD_W = DATA_W + LANES;

  typedef struct packed {
    logic [NSRC-1:0]  pop;
    logic             load;
    logic [1:0]       srcCode;
    logic [ROT_W-1:0] rot;
  } rxStrobe_t;
endpackage

// File: rtl/rxQueue.sv
module rxQueue #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 72,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [WORD_W-1:0] pushWord,
  input  logic              pop,
  output logic [WORD_W-1:0] headWord,
  output logic [CNT_W-1:0]  count,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] store [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic accept;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CNT_W'(DEPTH));
  assign accept   = push && !full;
  assign headWord = store[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (accept) wrPtr <= nextPtr(wrPtr);
      if (pop)    rdPtr <= nextPtr(rdPtr);
      case ({accept, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) store[wrPtr] <= pushWord;
  end

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (full && !pop) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/rxPathCtrl.sv
module rxPathCtrl
  import rxPathPkg::*;
#(
  parameter int CNT_W     = 7,
  parameter int THR_RESET = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cs,
  input  logic [1:0]                 srcSel,
  input  logic [ROT_W-1:0]           byteSel,
  input  logic [NSRC-1:0][CNT_W-1:0] qCount,
  input  logic                       cfgWe,
  input  logic                       cfgSel,
  input  logic [CNT_W-1:0]           cfgThr,
  output rxStrobe_t                  strobe,
  output logic [1:0]                 rxEmpty,
  output logic [1:0]                 rxAlmostEmpty
);
  logic [NSRC-1:0] qEmpty;
  logic [1:0][CNT_W-1:0] thr;

  for (genvar j = 0; j < NSRC; j++) begin : g_src
    assign qEmpty[j]     = (qCount[j] == '0);
    assign strobe.pop[j] = cs && (srcSel == 2'(j)) && !qEmpty[j];
  end

  for (genvar n = 0; n < 2; n++) begin : g_thr
    always_ff @(posedge clk) begin
      if (!rstN)                              thr[n] <= CNT_W'(THR_RESET);
      else if (cfgWe && (cfgSel == 1'(n)))    thr[n] <= cfgThr;
    end
    assign rxEmpty[n]       = qEmpty[n];
    assign rxAlmostEmpty[n] = (qCount[n] <= thr[n]);
  end

  assign strobe.load    = |strobe.pop;
  assign strobe.srcCode = srcSel;
  assign strobe.rot     = byteSel;

  assert_thr_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !cfgSel) |=> (thr[0] == $past(cfgThr)));
endmodule

// File: rtl/rxPathData.sv
module rxPathData
  import rxPathPkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int PW_DEPTH = 32,
  parameter int CNT_W    = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NSRC-1:0]             pushEn,
  input  logic [NSRC-1:0][DATA_W-1:0] pushData,
  input  logic [NSRC-1:0][LANES-1:0]  pushBe,
  input  rxStrobe_t                   strobe,
  output logic [NSRC-1:0][CNT_W-1:0]  qCount,
  output logic [NSRC-1:0]             qFull,
  output logic [DATA_W-1:0]           outData,
  output logic [LANES-1:0]            outBe,
  output logic [1:0]                  outByteId,
  output logic                        outValid
);
  logic [NSRC-1:0][WORD_W-1:0] head;
  logic [WORD_W-1:0] selWord;
  logic [DATA_W-1:0] selData, rotData;
  logic [LANES-1:0]  selBe, rotBe;

  for (genvar j = 0; j < NSRC; j++) begin : g_q
    localparam int QD = (j == NSRC - 1) ? PW_DEPTH : RX_DEPTH;
    rxQueue #(.DEPTH(QD), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_q (
      .clk      (clk),
      .rstN     (rstN),
      .push     (pushEn[j]),
      .pushWord ({pushBe[j], pushData[j]}),
      .pop      (strobe.pop[j]),
      .headWord (head[j]),
      .count    (qCount[j]),
      .full     (qFull[j])
    );
  end

  always_comb begin
    case (strobe.srcCode)
      2'd1:    selWord = head[1];
      2'd2:    selWord = head[2];
      default: selWord = head[0];
    endcase
  end

  assign selData = selWord[DATA_W-1:0];
  assign selBe   = selWord[WORD_W-1:DATA_W];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ROT_W-1:0] srcLane;
    assign srcLane = ROT_W'(i) + strobe.rot;
    assign rotData[i*LANE_W +: LANE_W] = selData[srcLane*LANE_W +: LANE_W];
    assign rotBe[i] = selBe[srcLane];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData   <= '0;
      outBe     <= '0;
      outByteId <= '0;
      outValid  <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        outData   <= rotData;
        outBe     <= rotBe;
        outByteId <= strobe.srcCode;
      end
    end
  end

  assert_single_pop_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.pop));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(outData) && $stable(outBe) && !outValid));

  assert_zero_rot_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.rot == '0) |=> (outBe == $past(selBe)));
endmodule

// File: rtl/rxPathTop.sv
module rxPathTop
  import rxPathPkg::*;
#(
  parameter int RX_DEPTH  = 64,
  parameter int PW_DEPTH  = 32,
  parameter int THR_RESET = 4,
  localparam int CNT_W    = $clog2(((RX_DEPTH > PW_DEPTH) ? RX_DEPTH : PW_DEPTH) + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NSRC-1:0]             pushEn,
  input  logic [NSRC-1:0][DATA_W-1:0] pushData,
  input  logic [NSRC-1:0][LANES-1:0]  pushBe,
  output logic [NSRC-1:0]             qFull,
  input  logic                        cs,
  input  logic [1:0]                  srcSel,
  input  logic [ROT_W-1:0]            byteSel,
  output logic [DATA_W-1:0]           outData,
  output logic [LANES-1:0]            outBe,
  output logic [1:0]                  outByteId,
  output logic                        outValid,
  output logic [1:0]                  rxEmpty,
  output logic [1:0]                  rxAlmostEmpty,
  input  logic                        cfgWe,
  input  logic                        cfgSel,
  input  logic [CNT_W-1:0]            cfgThr
);
  rxStrobe_t strobe;
  logic [NSRC-1:0][CNT_W-1:0] qCount;

  rxPathCtrl #(.CNT_W(CNT_W), .THR_RESET(THR_RESET)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cs            (cs),
    .srcSel        (srcSel),
    .byteSel       (byteSel),
    .qCount        (qCount),
    .cfgWe         (cfgWe),
    .cfgSel        (cfgSel),
    .cfgThr        (cfgThr),
    .strobe        (strobe),
    .rxEmpty       (rxEmpty),
    .rxAlmostEmpty (rxAlmostEmpty)
  );

  rxPathData #(.RX_DEPTH(RX_DEPTH), .PW_DEPTH(PW_DEPTH), .CNT_W(CNT_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .pushEn    (pushEn),
    .pushData  (pushData),
    .pushBe    (pushBe),
    .strobe    (strobe),
    .qCount    (qCount),
    .qFull     (qFull),
    .outData   (outData),
    .outBe     (outBe),
    .outByteId (outByteId),
    .outValid  (outValid)
  );

  assert_reserved_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'b11) |=> (!outValid && $stable(outData) && $stable(outByteId)));

  assert_no_cs_no_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cs |=> !outValid);

  assert_empty_within_almost_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxEmpty & ~rxAlmostEmpty) == 2'b00);

  assert_empty_no_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cs && srcSel == 2'b00 && rxEmpty[0]) |=> !outValid);
endmodule

// File: tb/tb_rxPathTop.sv
module tb_rxPathTop;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic [2:0] pushEn;
  logic [2:0][63:0] pushData;
  logic [2:0][7:0] pushBe;
  logic [2:0] qFull;
  logic cs;
  logic [1:0] srcSel;
  logic [2:0] byteSel;
  logic [63:0] outData;
  logic [7:0] outBe;
  logic [1:0] outByteId;
  logic outValid;
  logic [1:0] rxEmpty, rxAlmostEmpty;
  logic cfgWe, cfgSel;
  logic [6:0] cfgThr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxPathTop dut (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushData(pushData), .pushBe(pushBe),
    .qFull(qFull), .cs(cs), .srcSel(srcSel), .byteSel(byteSel), .outData(outData),
    .outBe(outBe), .outByteId(outByteId), .outValid(outValid), .rxEmpty(rxEmpty),
    .rxAlmostEmpty(rxAlmostEmpty), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgThr(cfgThr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [71:0] mdl [3][64];
  int hd[3], ct[3];
  int dep[3] = '{64, 64, 32};
  int thr[2];
  logic [63:0] expData;
  logic [7:0] expBe;
  logic [1:0] expId;
  logic expValid;

  function automatic logic [63:0] refRotD(input logic [63:0] w, input int k);
    logic [63:0] r;
    for (int l = 0; l < 8; l++) r[l*8 +: 8] = w[((l + k) % 8)*8 +: 8];
    return r;
  endfunction

  function automatic logic [7:0] refRotB(input logic [7:0] b, input int k);
    logic [7:0] r;
    for (int l = 0; l < 8; l++) r[l] = b[(l + k) % 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkOutputs(input logic [1:0] s, input logic [2:0] b, input bit popped);
    string dreq;
    dreq = (b == 0) ? "R3" : "R4";
    if (!popped) dreq = (s == 2'b11) ? "R6" : "R5";
    chk(outValid == expValid, popped ? "R5" : dreq, "valid", 64'(outValid), 64'(expValid));
    chk(outData == expData, dreq, "data", outData, expData);
    chk(outBe == expBe, dreq, "byte enables", 64'(outBe), 64'(expBe));
    chk(outByteId == expId, popped ? "R2" : dreq, "byte id", 64'(outByteId), 64'(expId));
    for (int n = 0; n < 2; n++) begin
      chk(rxEmpty[n] == (ct[n] == 0), "R8", "empty flag", 64'(rxEmpty[n]), 64'(ct[n] == 0));
      chk(rxAlmostEmpty[n] == (ct[n] <= thr[n]), "R9", "almost-empty flag",
          64'(rxAlmostEmpty[n]), 64'(ct[n] <= thr[n]));
    end
    for (int j = 0; j < 3; j++)
      chk(qFull[j] == (ct[j] == dep[j]), "R7", "full flag", 64'(qFull[j]), 64'(ct[j] == dep[j]));
  endtask

  // Drive at the falling edge, model the rising edge, check at the next falling edge.
  task automatic cycle(input logic [2:0] pEn, input logic c, input logic [1:0] s,
                       input logic [2:0] b, input logic we, input logic ws, input int wv);
    bit popIt;
    logic [71:0] w;
    pushEn = pEn; cs = c; srcSel = s; byteSel = b;
    cfgWe = we; cfgSel = ws; cfgThr = 7'(wv);
    for (int j = 0; j < 3; j++) begin
      pushData[j] = {$urandom, $urandom};
      pushBe[j] = 8'($urandom);
    end
    popIt = c && (s != 2'b11) && (ct[s] > 0);
    for (int j = 0; j < 3; j++) begin
      if (pEn[j] && ct[j] < dep[j]) begin
        mdl[j][(hd[j] + ct[j]) % dep[j]] = {pushBe[j], pushData[j]};
        ct[j]++;
      end
    end
    if (popIt) begin
      w = mdl[s][hd[s]];
      hd[s] = (hd[s] + 1) % dep[s];
      ct[s]--;
      expData = refRotD(w[63:0], int'(b));
      expBe = refRotB(w[71:64], int'(b));
      expId = s;
      expValid = 1'b1;
    end else begin
      expValid = 1'b0;
    end
    if (we) thr[ws] = wv;
    @(posedge clk);
    @(negedge clk);
    checkOutputs(s, b, popIt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int j = 0; j < 3; j++) begin hd[j] = 0; ct[j] = 0; end
    thr[0] = 4; thr[1] = 4;
    expData = '0; expBe = '0; expId = '0; expValid = 1'b0;
    rstN = 1'b0; pushEn = '0; pushData = '0; pushBe = '0; cs = 1'b0;
    srcSel = '0; byteSel = '0; cfgWe = 1'b0; cfgSel = 1'b0; cfgThr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(outValid == 1'b0, "R1", "valid", 64'(outValid), 64'd0);
    chk(outData == '0, "R1", "data", outData, 64'd0);
    chk(outBe == '0, "R1", "byte enables", 64'(outBe), 64'd0);
    chk(outByteId == '0, "R1", "byte id", 64'(outByteId), 64'd0);
    chk(rxEmpty == 2'b11, "R1", "empty", 64'(rxEmpty), 64'd3);
    chk(qFull == 3'b000, "R1", "full", 64'(qFull), 64'd0);
    rstN = 1'b1;

    // R1/R9: default threshold 4, almost-empty drops on the fifth word
    for (int k = 0; k < 5; k++) cycle(3'b001, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 0);
    chk(rxAlmostEmpty[0] == 1'b0, "R1", "threshold default", 64'(rxAlmostEmpty[0]), 64'd0);
    cycle(3'b000, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, 0);
    chk(rxAlmostEmpty[0] == 1'b1, "R9", "at threshold", 64'(rxAlmostEmpty[0]), 64'd1);

    // R3/R4: drain with several rotations
    for (int k = 1; k < 5; k++) cycle(3'b000, 1'b1, 2'd0, 3'(k), 1'b0, 1'b0, 0);
    // R8: empty queue gives no pop
    cycle(3'b000, 1'b1, 2'd0, 3'd2, 1'b0, 1'b0, 0);

    // R7: overfill the posted-write queue, then push and pop while full
    for (int k = 0; k < 34; k++) cycle(3'b100, 1'b0, 2'd2, 3'd0, 1'b0, 1'b0, 0);
    cycle(3'b100, 1'b1, 2'd2, 3'd0, 1'b0, 1'b0, 0);
    // R4: every rotation from the posted-write queue
    for (int k = 0; k < 8; k++) cycle(3'b000, 1'b1, 2'd2, 3'(k), 1'b0, 1'b0, 0);
    // R6: reserved select holds the last word
    cycle(3'b010, 1'b1, 2'b11, 3'd5, 1'b0, 1'b0, 0);
    cycle(3'b000, 1'b1, 2'b11, 3'd1, 1'b0, 1'b0, 0);
    // R2: DMA queue 1 with a rewritten threshold (R9)
    cycle(3'b010, 1'b0, 2'd1, 3'd0, 1'b1, 1'b1, 1);
    cycle(3'b000, 1'b1, 2'd1, 3'd7, 1'b1, 1'b1, 0);
    cycle(3'b000, 1'b1, 2'd1, 3'd6, 1'b0, 1'b0, 0);

    // Random traffic, push-heavy and pop-heavy phases
    for (int k = 0; k < 6000; k++) begin
      int phase;
      logic [2:0] pe;
      logic we;
      phase = (k / 500) % 2;
      pe = 3'($urandom);
      if (phase == 1) pe = pe & 3'($urandom) & 3'($urandom);
      we = (($urandom % 40) == 0);
      cycle(pe, (phase == 1) || (($urandom % 4) == 0), 2'($urandom), 3'($urandom),
            we, 1'($urandom), int'($urandom % 65));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule